// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block computes, in a single combinational step, every control-register and program-counter update a soft processor needs when it takes an exception. The pipeline raises a take strobe together with a 5-bit cause code and presents the current program counter plus the current status, cause and translation-miss control registers. The block returns the next value and a write enable for each register it may change. The processor's register file applies all enabled writes on the same clock edge, so an exception is entered in one cycle.

The causes fall into six groups: external interrupt, translation miss, translation permission fault, guarded faults (supervisor-only access, illegal instruction, trap), breakpoint, and unrecognised. The handler-active bit of the incoming status decides two things. It decides whether a translation miss uses the fast refill vector. It also decides whether the saved status and the return address are overwritten, so a fault taken inside a handler does not destroy the state the first entry captured. Bit positions, cause encodings and vector addresses are parameters. The take strobe is a plain control pin with no back-pressure: the pipeline raises it only in a cycle in which it commits to the exception.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On any recognised cause, the cause register write is enabled, bits 6:2 of the new value hold the 5-bit cause code, and all other bits equal the incoming cause register.
- R2: On an external interrupt (default code 2), saved exception status takes the incoming status. The new status has the interrupt-handler bit (default bit 3) set and the previous-enable (bit 0) and user (bit 1) bits cleared. The exception return address becomes PC+4 and the PC becomes the general vector.
- R3: On a translation miss (default code 14) with the handler bit (default bit 2) clear, the following are written: saved status, the return address PC+4, and the miss-control register with its double-miss bit (default 14) cleared and its write-pending bit (default 18) set. The PC becomes the fast refill vector.
- R4: On a translation miss with the handler bit set, saved status and the return address are not written. The miss-control register is written with the double-miss bit set and its other bits kept. The PC becomes the general vector.
- R5: On a read, write or execute permission fault (default codes 15, 16, 17), saved status and the return address PC+4 are written whatever the handler bit is, and the PC becomes the general vector.
- R6: On a trap (3), illegal instruction (5) or supervisor-only fault (9, 11, 12), saved status and the return address are written only when the handler bit was clear. The PC becomes the general vector.
- R7: On a breakpoint (default code 7), the break-saved status and the break return address PC+4 are written instead of the exception ones, and only when the handler bit was clear. The PC becomes the general vector, or the break vector when the break-vector option is enabled.
- R8: An unrecognised cause with the take strobe high raises the error output, and every write enable stays low.
- R9: With the take strobe low, every write enable and the error output are low.
- R10: For every recognised cause other than an interrupt, the new status has the handler bit set, the previous-enable and user bits cleared, and all other bits equal to the incoming status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| take_i | input | 1 | Exception is taken this cycle |
| cause_i | input | 5 | Cause code |
| pc_i | input | 32 | Current program counter |
| status_i | input | 32 | Current status register |
| cause_reg_i | input | 32 | Current cause register |
| tlbctl_i | input | 32 | Current translation-miss control register |
| status_we_o | output | 1 | Status write enable |
| status_o | output | 32 | Next status |
| esave_we_o | output | 1 | Saved exception status write enable |
| esave_o | output | 32 | Next saved exception status |
| bsave_we_o | output | 1 | Saved break status write enable |
| bsave_o | output | 32 | Next saved break status |
| eret_we_o | output | 1 | Exception return address write enable |
| eret_o | output | 32 | Next exception return address |
| bret_we_o | output | 1 | Break return address write enable |
| bret_o | output | 32 | Next break return address |
| cause_we_o | output | 1 | Cause register write enable |
| cause_reg_o | output | 32 | Next cause register |
| tlbctl_we_o | output | 1 | Miss-control register write enable |
| tlbctl_o | output | 32 | Next miss-control register |
| pc_we_o | output | 1 | Program counter write enable |
| pc_o | output | 32 | Next program counter |
| bad_cause_o | output | 1 | Take strobe with an unrecognised cause |

## Verification
The block holds no state, so a wrong internal decision shows on the ports in the same cycle as the take strobe. A misclassified cause shows as the wrong pattern of write enables. A wrong handler-bit test shows as a saved status or return address written during a nested fault, or left unwritten on a first entry. A wrong vector choice shows on the next PC, and a slip in the cause field position corrupts the neighbouring bits of the cause register. Each stimulus row therefore compares the whole set of enables and every enabled value. The rows cover both handler-bit states for each group.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    CL_NONE    = 3'd0,
    CL_IRQ     = 3'd1,
    CL_TLBMISS = 3'd2,
    CL_PERM    = 3'd3,
    CL_GUARD   = 3'd4,
    CL_BREAK   = 3'd5
  } exc_class_e;

  typedef struct packed {
    logic esave;
    logic bsave;
    logic eret;
    logic bret;
  } save_we_t;
endpackage

// File: rtl/exc_cause_decode.sv
module exc_cause_decode
  import exc_pkg::*;
#(
  parameter int CW            = 5,
  parameter int C_IRQ         = 2,
  parameter int C_TRAP        = 3,
  parameter int C_ILLEGAL     = 5,
  parameter int C_BREAK       = 7,
  parameter int C_SUPER_INSN  = 9,
  parameter int C_SUPER_ADDR  = 11,
  parameter int C_SUPER_DATA  = 12,
  parameter int C_TLB_MISS    = 14,
  parameter int C_TLB_READ    = 15,
  parameter int C_TLB_WRITE   = 16,
  parameter int C_TLB_EXEC    = 17
) (
  input  logic [CW-1:0] cause_i,
  output exc_class_e    class_o
);
  always_comb begin
    class_o = CL_NONE;
    if (cause_i == CW'(C_IRQ))
      class_o = CL_IRQ;
    else if (cause_i == CW'(C_TLB_MISS))
      class_o = CL_TLBMISS;
    else if (cause_i == CW'(C_TLB_READ) || cause_i == CW'(C_TLB_WRITE) ||
             cause_i == CW'(C_TLB_EXEC))
      class_o = CL_PERM;
    else if (cause_i == CW'(C_TRAP) || cause_i == CW'(C_ILLEGAL) ||
             cause_i == CW'(C_SUPER_INSN) || cause_i == CW'(C_SUPER_ADDR) ||
             cause_i == CW'(C_SUPER_DATA))
      class_o = CL_GUARD;
    else if (cause_i == CW'(C_BREAK))
      class_o = CL_BREAK;
  end
endmodule

// File: rtl/exc_status_calc.sv
module exc_status_calc
  import exc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int B_PIE  = 0,
  parameter int B_USER = 1,
  parameter int B_EH   = 2,
  parameter int B_IH   = 3
) (
  input  exc_class_e       class_i,
  input  logic [XLEN-1:0]  status_i,
  output logic [XLEN-1:0]  status_o,
  output logic             eh_o
);
  assign eh_o = status_i[B_EH];

  always_comb begin
    status_o = status_i;
    if (class_i == CL_IRQ)
      status_o[B_IH] = 1'b1;
    else
      status_o[B_EH] = 1'b1;
    status_o[B_PIE]  = 1'b0;
    status_o[B_USER] = 1'b0;
  end

  always_comb begin
    if (class_i != CL_NONE && class_i != CL_IRQ) begin
      p_handler_set_r10: assert (status_o[B_EH] && !status_o[B_PIE] && !status_o[B_USER])
        else $error("handler bit not set on fault entry");
    end
  end
endmodule

// File: rtl/exc_save_ctrl.sv
module exc_save_ctrl
  import exc_pkg::*;
(
  input  logic       take_i,
  input  exc_class_e class_i,
  input  logic       eh_i,
  output save_we_t   we_o
);
  logic fresh;
  assign fresh = take_i && !eh_i;

  always_comb begin
    we_o = '0;
    unique case (class_i)
      CL_IRQ, CL_PERM: begin
        we_o.esave = take_i;
        we_o.eret  = take_i;
      end
      CL_TLBMISS, CL_GUARD: begin
        we_o.esave = fresh;
        we_o.eret  = fresh;
      end
      CL_BREAK: begin
        we_o.bsave = fresh;
        we_o.bret  = fresh;
      end
      default: we_o = '0;
    endcase
  end

  always_comb begin
    p_one_save_bank_r7: assert (!((we_o.esave || we_o.eret) && (we_o.bsave || we_o.bret)))
      else $error("both save banks enabled");
    if (take_i && eh_i && (class_i == CL_GUARD || class_i == CL_BREAK || class_i == CL_TLBMISS)) begin
      p_nested_keeps_r6: assert (we_o == '0)
        else $error("nested fault overwrote saved state");
    end
  end
endmodule

// File: rtl/exc_target_sel.sv
module exc_target_sel
  import exc_pkg::*;
#(
  parameter int               XLEN        = 32,
  parameter logic [XLEN-1:0]  VEC_GENERAL = 32'h0800_0020,
  parameter logic [XLEN-1:0]  VEC_REFILL  = 32'h0400_0100,
  parameter logic [XLEN-1:0]  VEC_BREAK   = 32'h0A00_0000,
  parameter bit               BRK_OWN_VEC = 1'b0
) (
  input  exc_class_e      class_i,
  input  logic            eh_i,
  output logic [XLEN-1:0] target_o
);
  logic [XLEN-1:0] brk_target;

  generate
    if (BRK_OWN_VEC) begin : g_brk_own
      assign brk_target = VEC_BREAK;
    end else begin : g_brk_shared
      assign brk_target = VEC_GENERAL;
    end
  endgenerate

  always_comb begin
    if (class_i == CL_TLBMISS && !eh_i)
      target_o = VEC_REFILL;
    else if (class_i == CL_BREAK)
      target_o = brk_target;
    else
      target_o = VEC_GENERAL;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int               XLEN         = 32,
  parameter int               CW           = 5,
  parameter int               CAUSE_LSB    = 2,
  parameter int               B_PIE        = 0,
  parameter int               B_USER       = 1,
  parameter int               B_EH         = 2,
  parameter int               B_IH         = 3,
  parameter int               B_DBLMISS    = 14,
  parameter int               B_WRPEND     = 18,
  parameter int               C_IRQ        = 2,
  parameter int               C_TRAP       = 3,
  parameter int               C_ILLEGAL    = 5,
  parameter int               C_BREAK      = 7,
  parameter int               C_SUPER_INSN = 9,
  parameter int               C_SUPER_ADDR = 11,
  parameter int               C_SUPER_DATA = 12,
  parameter int               C_TLB_MISS   = 14,
  parameter int               C_TLB_READ   = 15,
  parameter int               C_TLB_WRITE  = 16,
  parameter int               C_TLB_EXEC   = 17,
  parameter logic [XLEN-1:0]  VEC_GENERAL  = 32'h0800_0020,
  parameter logic [XLEN-1:0]  VEC_REFILL   = 32'h0400_0100,
  parameter logic [XLEN-1:0]  VEC_BREAK    = 32'h0A00_0000,
  parameter bit               BRK_OWN_VEC  = 1'b0
) (
  input  logic            take_i,
  input  logic [CW-1:0]   cause_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] status_i,
  input  logic [XLEN-1:0] cause_reg_i,
  input  logic [XLEN-1:0] tlbctl_i,
  output logic            status_we_o,
  output logic [XLEN-1:0] status_o,
  output logic            esave_we_o,
  output logic [XLEN-1:0] esave_o,
  output logic            bsave_we_o,
  output logic [XLEN-1:0] bsave_o,
  output logic            eret_we_o,
  output logic [XLEN-1:0] eret_o,
  output logic            bret_we_o,
  output logic [XLEN-1:0] bret_o,
  output logic            cause_we_o,
  output logic [XLEN-1:0] cause_reg_o,
  output logic            tlbctl_we_o,
  output logic [XLEN-1:0] tlbctl_o,
  output logic            pc_we_o,
  output logic [XLEN-1:0] pc_o,
  output logic            bad_cause_o
);
  localparam int CAUSE_MSB = CAUSE_LSB + CW - 1;
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  exc_class_e cls;
  logic       eh;
  logic       known;
  save_we_t   save_we;
  logic [XLEN-1:0] link;

  exc_cause_decode #(
    .CW(CW), .C_IRQ(C_IRQ), .C_TRAP(C_TRAP), .C_ILLEGAL(C_ILLEGAL),
    .C_BREAK(C_BREAK), .C_SUPER_INSN(C_SUPER_INSN), .C_SUPER_ADDR(C_SUPER_ADDR),
    .C_SUPER_DATA(C_SUPER_DATA), .C_TLB_MISS(C_TLB_MISS), .C_TLB_READ(C_TLB_READ),
    .C_TLB_WRITE(C_TLB_WRITE), .C_TLB_EXEC(C_TLB_EXEC)
  ) u_decode (
    .cause_i (cause_i),
    .class_o (cls)
  );

  exc_status_calc #(
    .XLEN(XLEN), .B_PIE(B_PIE), .B_USER(B_USER), .B_EH(B_EH), .B_IH(B_IH)
  ) u_status (
    .class_i  (cls),
    .status_i (status_i),
    .status_o (status_o),
    .eh_o     (eh)
  );

  exc_save_ctrl u_save (
    .take_i  (take_i),
    .class_i (cls),
    .eh_i    (eh),
    .we_o    (save_we)
  );

  exc_target_sel #(
    .XLEN(XLEN), .VEC_GENERAL(VEC_GENERAL), .VEC_REFILL(VEC_REFILL),
    .VEC_BREAK(VEC_BREAK), .BRK_OWN_VEC(BRK_OWN_VEC)
  ) u_target (
    .class_i  (cls),
    .eh_i     (eh),
    .target_o (pc_o)
  );

  assign known = (cls != CL_NONE);
  assign link  = pc_i + INSN_BYTES;

  assign esave_o = status_i;
  assign bsave_o = status_i;
  assign eret_o  = link;
  assign bret_o  = link;

  assign esave_we_o = save_we.esave;
  assign eret_we_o  = save_we.eret;
  assign bsave_we_o = save_we.bsave;
  assign bret_we_o  = save_we.bret;

  assign status_we_o = take_i && known;
  assign cause_we_o  = take_i && known;
  assign pc_we_o     = take_i && known;
  assign bad_cause_o = take_i && !known;
  assign tlbctl_we_o = take_i && (cls == CL_TLBMISS);

  always_comb begin
    cause_reg_o = cause_reg_i;
    cause_reg_o[CAUSE_MSB:CAUSE_LSB] = cause_i;
  end

  always_comb begin
    tlbctl_o = tlbctl_i;
    if (eh) begin
      tlbctl_o[B_DBLMISS] = 1'b1;
    end else begin
      tlbctl_o[B_DBLMISS] = 1'b0;
      tlbctl_o[B_WRPEND]  = 1'b1;
    end
  end

  always_comb begin
    if (cause_we_o) begin
      p_cause_field_r1: assert (cause_reg_o[CAUSE_MSB:CAUSE_LSB] == cause_i &&
                                cause_reg_o[1:0] == cause_reg_i[1:0])
        else $error("cause field misplaced");
    end
    if (bad_cause_o) begin
      p_bad_quiet_r8: assert (!status_we_o && !esave_we_o && !bsave_we_o && !eret_we_o &&
                              !bret_we_o && !cause_we_o && !tlbctl_we_o && !pc_we_o)
        else $error("write enabled on unknown cause");
    end
    if (take_i == 1'b0) begin
      p_idle_r9: assert (!status_we_o && !esave_we_o && !bsave_we_o && !eret_we_o &&
                         !bret_we_o && !cause_we_o && !tlbctl_we_o && !pc_we_o && !bad_cause_o)
        else $error("activity without take strobe");
    end
    if (tlbctl_we_o && !status_i[B_EH]) begin
      p_refill_path_r3: assert (pc_o == VEC_REFILL && esave_we_o && eret_we_o)
        else $error("first-level miss took wrong path");
    end
    if (tlbctl_we_o && status_i[B_EH]) begin
      p_double_miss_r4: assert (tlbctl_o[B_DBLMISS] && !esave_we_o && !eret_we_o)
        else $error("nested miss handled wrongly");
    end
  end
endmodule

// File: tb/exc_entry_ctrl_tb_top.sv
module exc_entry_ctrl_tb_top;
  localparam logic [31:0] GEN = 32'h0800_0020;
  localparam logic [31:0] REF = 32'h0400_0100;
  localparam logic [31:0] BRK = 32'h0A00_0000;
  localparam int NV = 14;

  // mask bits: [8]status [7]esave [6]bsave [5]eret [4]bret [3]cause [2]tlbctl [1]pc [0]bad
  typedef struct packed {
    logic        take;
    logic [4:0]  cause;
    logic [31:0] status;
    logic [8:0]  mask;
    logic [31:0] pc_exp;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'd2,  32'h0000_0003, 9'b110101010, GEN},  // R2 interrupt
    '{1'b1, 5'd2,  32'h0000_0007, 9'b110101010, GEN},  // R2 interrupt in handler
    '{1'b1, 5'd14, 32'h0000_0003, 9'b110101110, REF},  // R3 first-level miss
    '{1'b1, 5'd14, 32'h0000_0007, 9'b100001110, GEN},  // R4 nested miss
    '{1'b1, 5'd15, 32'h0000_0007, 9'b110101010, GEN},  // R5 read perm, nested
    '{1'b1, 5'd16, 32'h0000_0003, 9'b110101010, GEN},  // R5 write perm
    '{1'b1, 5'd17, 32'h0000_0006, 9'b110101010, GEN},  // R5 exec perm
    '{1'b1, 5'd3,  32'h0000_0003, 9'b110101010, GEN},  // R6 trap fresh
    '{1'b1, 5'd5,  32'h0000_0007, 9'b100001010, GEN},  // R6 illegal nested
    '{1'b1, 5'd11, 32'h0000_0003, 9'b110101010, GEN},  // R6 supervisor fresh
    '{1'b1, 5'd7,  32'h0000_0003, 9'b101011010, GEN},  // R7 break fresh
    '{1'b1, 5'd7,  32'h0000_0007, 9'b100001010, GEN},  // R7 break nested
    '{1'b1, 5'd20, 32'h0000_0003, 9'b000000001, GEN},  // R8 unknown cause
    '{1'b0, 5'd2,  32'h0000_0003, 9'b000000000, GEN}   // R9 no strobe
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        take;
  logic [4:0]  cause;
  logic [31:0] pc, status, creg, tctl;
  logic        s_we, es_we, bs_we, er_we, br_we, c_we, t_we, p_we, bad;
  logic [31:0] s_o, es_o, bs_o, er_o, br_o, c_o, t_o, p_o;
  logic        b2_s_we, b2_es_we, b2_bs_we, b2_er_we, b2_br_we, b2_c_we, b2_t_we, b2_p_we, b2_bad;
  logic [31:0] b2_s_o, b2_es_o, b2_bs_o, b2_er_o, b2_br_o, b2_c_o, b2_t_o, b2_p_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  exc_entry_ctrl dut_i (
    .take_i(take), .cause_i(cause), .pc_i(pc), .status_i(status),
    .cause_reg_i(creg), .tlbctl_i(tctl),
    .status_we_o(s_we), .status_o(s_o), .esave_we_o(es_we), .esave_o(es_o),
    .bsave_we_o(bs_we), .bsave_o(bs_o), .eret_we_o(er_we), .eret_o(er_o),
    .bret_we_o(br_we), .bret_o(br_o), .cause_we_o(c_we), .cause_reg_o(c_o),
    .tlbctl_we_o(t_we), .tlbctl_o(t_o), .pc_we_o(p_we), .pc_o(p_o),
    .bad_cause_o(bad)
  );

  exc_entry_ctrl #(.BRK_OWN_VEC(1'b1)) dut_brk_i (
    .take_i(take), .cause_i(cause), .pc_i(pc), .status_i(status),
    .cause_reg_i(creg), .tlbctl_i(tctl),
    .status_we_o(b2_s_we), .status_o(b2_s_o), .esave_we_o(b2_es_we), .esave_o(b2_es_o),
    .bsave_we_o(b2_bs_we), .bsave_o(b2_bs_o), .eret_we_o(b2_er_we), .eret_o(b2_er_o),
    .bret_we_o(b2_br_we), .bret_o(b2_br_o), .cause_we_o(b2_c_we), .cause_reg_o(b2_c_o),
    .tlbctl_we_o(b2_t_we), .tlbctl_o(b2_t_o), .pc_we_o(b2_p_we), .pc_o(b2_p_o),
    .bad_cause_o(b2_bad)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] status_exp(input logic [4:0] c, input logic [31:0] s);
    logic [31:0] r = s;
    if (c == 5'd2) r[3] = 1'b1; else r[2] = 1'b1;
    r[1:0] = 2'b00;
    return r;
  endfunction

  task automatic check_outputs(input string req, input logic [8:0] mask, input logic [31:0] pcx);
    logic [31:0] ce;
    logic [31:0] te;
    chk({req, " enables"}, {23'd0, s_we, es_we, bs_we, er_we, br_we, c_we, t_we, p_we, bad},
        {23'd0, mask});
    if (mask[8]) chk({req, " status R10"}, s_o, status_exp(cause, status));
    if (mask[7]) chk({req, " esave"}, es_o, status);
    if (mask[6]) chk({req, " bsave R7"}, bs_o, status);
    if (mask[5]) chk({req, " eret"}, er_o, pc + 32'd4);
    if (mask[4]) chk({req, " bret R7"}, br_o, pc + 32'd4);
    if (mask[3]) begin
      ce = {creg[31:7], cause, creg[1:0]};
      chk({req, " cause R1"}, c_o, ce);
    end
    if (mask[2]) begin
      te = tctl;
      if (status[2]) te[14] = 1'b1;
      else begin te[14] = 1'b0; te[18] = 1'b1; end
      chk({req, " tlbctl"}, t_o, te);
    end
    if (mask[1]) chk({req, " pc"}, p_o, pcx);
  endtask

  initial begin : watchdog
    while (cycles < 5000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog actual=%0d expected<5000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    take = 1'b0; cause = 5'd0; pc = 32'h0; status = 32'h0;
    creg = 32'hFFFF_FF83; tctl = 32'h0000_4001;
    @(negedge clk);
    // R9: quiescent start, nothing enabled
    check_outputs("R9 start", 9'b0, GEN);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      take   = VECS[i].take;
      cause  = VECS[i].cause;
      status = VECS[i].status;
      pc     = 32'h0000_1000 + 32'(i) * 32'h40;
      tctl   = (i % 2 == 0) ? 32'h0000_4001 : 32'h0000_0001;
      #1;
      check_outputs($sformatf("row%0d", i), VECS[i].mask, VECS[i].pc_exp);
    end

    // R10: unrelated status bits preserved on fault entry
    @(negedge clk);
    take = 1'b1; cause = 5'd12; status = 32'hA5A5_00F3; pc = 32'hFFFF_FFFC; creg = 32'h0000_0000;
    #1;
    check_outputs("R10 preserve", 9'b110101010, GEN);
    chk("R10 upper bits", s_o, 32'hA5A5_00F4);
    chk("R1 cause zero bg", c_o, 32'h0000_0030);
    chk("R5 R6 wrap link", er_o, 32'h0000_0000);

    // R8: code boundaries 0 and 31 unknown
    @(negedge clk);
    cause = 5'd0; status = 32'h3; #1;
    check_outputs("R8 code0", 9'b000000001, GEN);
    @(negedge clk);
    cause = 5'd31; #1;
    check_outputs("R8 code31", 9'b000000001, GEN);

    // R7: break with own-vector option
    @(negedge clk);
    cause = 5'd7; status = 32'h3; #1;
    chk("R7 own vector", b2_p_o, BRK);
    chk("R7 own vector save", {31'd0, b2_bs_we}, 32'd1);
    // R3: refill vector unaffected by break option
    @(negedge clk);
    cause = 5'd14; #1;
    chk("R3 refill alt", b2_p_o, REF);

    @(negedge clk);
    take = 1'b0; #1;
    check_outputs("R9 end", 9'b0, GEN);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule